// File: doc/BRIEF.md
# QP-Controlled Coefficient Quantizer

This block turns integer-transform coefficients of 4×4 blocks into quantized levels for an intra-only video encoder. Coefficients stream in one per clock in raster order within each block. Each one is multiplied by a scale factor. The factor is chosen from the run-time quality parameter (QP) and from the coefficient's place in the block. The product is rounded and shifted right, and the original sign is put back. Because the forward transform's normalisation gains are folded into these factors, the transform ahead of this block can be built from shifts and adds alone.

The QP input is sampled once per block, at the block's first coefficient, and is clamped to the legal ceiling. A lower QP keeps more precision, which means higher quality and less compression. Results leave a fixed number of cycles after entry. Each result carries the index of its coefficient within the block, so that a downstream entropy coder can follow the block structure.

Top module: `coef_quantizer`

## Requirements
- R1: While reset is asserted and in the cycles after it with no input, `out_valid` stays 0.
- R2: Each coefficient accepted with `in_valid`=1 gives exactly one result with `out_valid`=1, exactly two clock edges after the edge that sampled it. Idle cycles between inputs are allowed and produce no result.
- R3: Accepted coefficients are counted modulo 16, and a count of 0 starts a block. `out_pos` gives the index k = 4*row + col of the result, where row = k[3:2] and col = k[1:0]. Idle cycles do not advance the count.
- R4: The scale factor depends on m = QP mod 6 and on the position class: class E when row and col are both even, class O when both are odd, class X otherwise. Factors (E,O,X) for m = 0..5: (13107,5243,8066), (11916,4660,7490), (10082,4194,6554), (9362,3647,5825), (8192,3355,5243), (7282,2893,4559).
- R5: With shift s = 15 + floor(QP/6) and offset f = floor(2^s / 3), the magnitude of the result is floor((|c|*factor + f) / 2^s), where c is the coefficient.
- R6: A negative coefficient gives the negated magnitude, a positive one gives the magnitude, and a zero coefficient gives 0.
- R7: A QP input above 51 is treated as 51, so QP values from 52 to 63 give the same results as 51.
- R8: The QP used for a whole block is the value present with the block's first coefficient (index 0). QP changes during indices 1 to 15 have no effect on that block.
- R9: The magnitude of a result never exceeds the magnitude of its coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Coefficient present this cycle |
| in_coef | input | COEF_W (16) | Signed transform coefficient |
| qp_in | input | 6 | Quality parameter, sampled at each block's first coefficient |
| out_valid | output | 1 | Result present this cycle |
| out_level | output | COEF_W (16) | Signed quantized level |
| out_pos | output | 4 | Index of the result within its 4×4 block |

## Verification
The bench changes QP on every cycle in the middle of blocks. A design that samples QP per coefficient instead of per block would then return levels scaled for the wrong step. QP values from 52 to 63 are driven as well: a design that wraps or passes them through would use the wrong table row and a shift of up to 25, and its levels would drop well below the clamped result. Extreme coefficients (-32768, 32767, ±1, 0) and long idle gaps inside a block test the sign restore, the width of the product and the position count. A design that advances the count on idle cycles would pick the wrong position class, and a design that rounds a signed value before taking its magnitude would give asymmetric results for ±c.

// File: rtl/cq_pkg.sv
package cq_pkg;
    localparam int MF_W  = 14;
    localparam int QP_W  = 6;
    localparam int SH_W  = 5;
    localparam int QP_MAX = 51;

    typedef enum logic [1:0] {CLS_EVEN = 2'd0, CLS_ODD = 2'd1, CLS_MIX = 2'd2} pos_cls_e;

    function automatic logic [MF_W-1:0] mf_lookup(input logic [2:0] m, input pos_cls_e cls);
        logic [MF_W-1:0] e, o, x;
        case (m)
            3'd0:    begin e = 14'd13107; o = 14'd5243; x = 14'd8066; end
            3'd1:    begin e = 14'd11916; o = 14'd4660; x = 14'd7490; end
            3'd2:    begin e = 14'd10082; o = 14'd4194; x = 14'd6554; end
            3'd3:    begin e = 14'd9362;  o = 14'd3647; x = 14'd5825; end
            3'd4:    begin e = 14'd8192;  o = 14'd3355; x = 14'd5243; end
            default: begin e = 14'd7282;  o = 14'd2893; x = 14'd4559; end
        endcase
        case (cls)
            CLS_EVEN: return e;
            CLS_ODD:  return o;
            default:  return x;
        endcase
    endfunction
endpackage

// File: rtl/cq_block_seq.sv
module cq_block_seq
    import cq_pkg::*;
#(
    parameter int POS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [QP_W-1:0]  qp_in,
    output logic [POS_W-1:0] pos,
    output logic [QP_W-1:0]  qp_eff
);
    typedef struct packed {
        logic [POS_W-1:0] cnt;
        logic [QP_W-1:0]  qp;
    } seq_t;

    seq_t st_d, st_q;
    logic [QP_W-1:0] qp_clamped;

    always_comb begin
        qp_clamped = (qp_in > QP_W'(QP_MAX)) ? QP_W'(QP_MAX) : qp_in;
        st_d       = st_q;
        qp_eff     = (st_q.cnt == '0) ? qp_clamped : st_q.qp;
        pos        = st_q.cnt;
        if (in_valid) begin
            st_d.cnt = st_q.cnt + POS_W'(1);
            if (st_q.cnt == '0) begin
                st_d.qp = qp_clamped;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cq_scale_sel.sv
module cq_scale_sel
    import cq_pkg::*;
#(
    parameter int POS_W = 4
) (
    input  logic [POS_W-1:0] pos,
    input  logic [QP_W-1:0]  qp,
    output logic [MF_W-1:0]  mf,
    output logic [SH_W-1:0]  shift
);
    localparam int HALF = POS_W / 2;

    logic [QP_W-1:0] qp_div;
    logic [QP_W-1:0] qp_mod;
    logic            row_odd, col_odd;
    pos_cls_e        cls;

    always_comb begin
        qp_div  = qp / QP_W'(6);
        qp_mod  = qp - QP_W'(qp_div * QP_W'(6));
        row_odd = pos[HALF];
        col_odd = pos[0];
        if (!row_odd && !col_odd) begin
            cls = CLS_EVEN;
        end else if (row_odd && col_odd) begin
            cls = CLS_ODD;
        end else begin
            cls = CLS_MIX;
        end
        mf    = mf_lookup(qp_mod[2:0], cls);
        shift = SH_W'(15) + SH_W'(qp_div);
    end
endmodule

// File: rtl/cq_pipe.sv
module cq_pipe
    import cq_pkg::*;
#(
    parameter int COEF_W = 16,
    parameter int POS_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [COEF_W-1:0] in_coef,
    input  logic [MF_W-1:0]          mf,
    input  logic [SH_W-1:0]          shift,
    input  logic [POS_W-1:0]         pos,
    output logic                     out_valid,
    output logic signed [COEF_W-1:0] out_level,
    output logic [POS_W-1:0]         out_pos
);
    localparam int ACC_W = COEF_W + MF_W + 1;

    typedef struct packed {
        logic              v;
        logic              neg;
        logic [COEF_W-1:0] mag;
        logic [MF_W-1:0]   mf;
        logic [SH_W-1:0]   sh;
        logic [POS_W-1:0]  pos;
    } s1_t;

    typedef struct packed {
        logic              v;
        logic [COEF_W-1:0] lvl;
        logic [POS_W-1:0]  pos;
    } s2_t;

    s1_t s1_d, s1_q;
    s2_t s2_d, s2_q;
    logic [ACC_W-1:0]  prod, rnd, acc, quo;
    logic [COEF_W-1:0] qmag;

    always_comb begin
        s1_d.v   = in_valid;
        s1_d.neg = in_coef[COEF_W-1];
        s1_d.mag = in_coef[COEF_W-1] ? (~in_coef + COEF_W'(1)) : in_coef;
        s1_d.mf  = mf;
        s1_d.sh  = shift;
        s1_d.pos = pos;

        prod = ACC_W'(s1_q.mag) * ACC_W'(s1_q.mf);
        rnd  = (ACC_W'(1) << s1_q.sh) / ACC_W'(3);
        acc  = prod + rnd;
        quo  = acc >> s1_q.sh;
        qmag = quo[COEF_W-1:0];

        s2_d.v   = s1_q.v;
        s2_d.lvl = s1_q.neg ? (~qmag + COEF_W'(1)) : qmag;
        s2_d.pos = s1_q.pos;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_valid = s2_q.v;
    assign out_level = s2_q.lvl;
    assign out_pos   = s2_q.pos;
endmodule

// File: rtl/coef_quantizer.sv
module coef_quantizer
    import cq_pkg::*;
#(
    parameter int COEF_W = 16,
    parameter int BLK    = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [COEF_W-1:0] in_coef,
    input  logic [5:0]               qp_in,
    output logic                     out_valid,
    output logic signed [COEF_W-1:0] out_level,
    output logic [2*$clog2(BLK)-1:0] out_pos
);
    localparam int POS_W = 2 * $clog2(BLK);

    logic [POS_W-1:0] pos;
    logic [QP_W-1:0]  qp_eff;
    logic [MF_W-1:0]  mf;
    logic [SH_W-1:0]  shift;

    cq_block_seq #(.POS_W(POS_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .qp_in(qp_in),
        .pos(pos), .qp_eff(qp_eff)
    );

    cq_scale_sel #(.POS_W(POS_W)) u_sel (
        .pos(pos), .qp(qp_eff), .mf(mf), .shift(shift)
    );

    cq_pipe #(.COEF_W(COEF_W), .POS_W(POS_W)) u_pipe (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_coef(in_coef),
        .mf(mf), .shift(shift), .pos(pos),
        .out_valid(out_valid), .out_level(out_level), .out_pos(out_pos)
    );
endmodule

// File: rtl/cq_checker.sv
module cq_checker #(
    parameter int COEF_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic signed [COEF_W-1:0] in_coef,
    input logic                     out_valid,
    input logic signed [COEF_W-1:0] out_level
);
    logic [COEF_W:0] in_mag, out_mag;
    assign in_mag  = in_coef[COEF_W-1]   ? (COEF_W+1)'(-in_coef)   : (COEF_W+1)'(in_coef);
    assign out_mag = out_level[COEF_W-1] ? (COEF_W+1)'(-out_level) : (COEF_W+1)'(out_level);

    AST_LATENCY_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);                                        // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);                                      // R2
    AST_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_coef == '0) |-> ##2 (out_level == '0));            // R6
    AST_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_level != '0) |-> (out_level[COEF_W-1] == $past(in_coef[COEF_W-1], 2))); // R6
    AST_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mag <= $past(in_mag, 2)));                       // R9
endmodule

bind coef_quantizer cq_checker #(.COEF_W(COEF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_coef(in_coef),
    .out_valid(out_valid), .out_level(out_level)
);

// File: tb/tb_coef_quantizer.sv
module tb_coef_quantizer;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [15:0] in_coef = '0;
    logic [5:0]        qp_in = '0;
    logic              out_valid;
    logic signed [15:0] out_level;
    logic [3:0]        out_pos;

    int compared = 0;
    int mismatched = 0;

    // reference state: block counter and latched QP
    int ref_k = 0;
    int ref_qp = 0;
    // two-deep expectation line
    bit    e1_v = 0, e2_v = 0;
    int    e1_l = 0, e2_l = 0, e1_p = 0, e2_p = 0;
    string e1_t = "R1", e2_t = "R1";

    always #5 clk = ~clk;

    coef_quantizer dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_coef(in_coef),
        .qp_in(qp_in), .out_valid(out_valid), .out_level(out_level), .out_pos(out_pos)
    );

    function automatic int factor(int m, int k);
        int row = k / 4;
        int col = k % 4;
        int e, o, x;
        case (m)
            0: begin e = 13107; o = 5243; x = 8066; end
            1: begin e = 11916; o = 4660; x = 7490; end
            2: begin e = 10082; o = 4194; x = 6554; end
            3: begin e = 9362;  o = 3647; x = 5825; end
            4: begin e = 8192;  o = 3355; x = 5243; end
            default: begin e = 7282; o = 2893; x = 4559; end
        endcase
        if (row % 2 == 0 && col % 2 == 0) return e;
        if (row % 2 == 1 && col % 2 == 1) return o;
        return x;
    endfunction

    function automatic int quant(int c, int qp, int k);
        longint a = (c < 0) ? -c : c;
        int s = 15 + qp / 6;
        longint r = (a * factor(qp % 6, k) + ((longint'(1) << s) / 3)) >> s;
        return (c < 0) ? -int'(r) : int'(r);
    endfunction

    task automatic report(string tag, string what, int act, int exp);
        mismatched++;
        $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    endtask

    // one cycle: compare outputs due now, then drive the next input
    task automatic step(bit v, int c, int qp, string tag);
        @(negedge clk);
        compared++;
        if (out_valid !== e2_v) begin
            report(e2_t, "out_valid", int'(out_valid), int'(e2_v));
        end else if (e2_v) begin
            if (int'(out_level) != e2_l) report(e2_t, "out_level", int'(out_level), e2_l);
            else if (int'(out_pos) != e2_p) report(e2_t, "out_pos", int'(out_pos), e2_p);
        end
        e2_v = e1_v; e2_l = e1_l; e2_p = e1_p; e2_t = e1_t;
        in_valid = v; in_coef = 16'(c); qp_in = 6'(qp);
        e1_v = v; e1_t = tag;
        if (v) begin
            if (ref_k == 0) ref_qp = (qp > 51) ? 51 : qp;   // R7, R8
            e1_l = quant(c, ref_qp, ref_k);
            e1_p = ref_k;
            ref_k = (ref_k + 1) % 16;
        end
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, tag);
    endtask

    initial begin
        #1_000_000;
        mismatched++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", compared, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            compared++;
            if (out_valid !== 1'b0) report("R1", "out_valid in reset", int'(out_valid), 0);
        end
        rst_n = 1'b1;
        idle(3, "R1");

        // R4 R5: known values at QP 0, every position class
        for (int k = 0; k < 16; k++) step(1, (k % 2) ? -100 : 100, 0, "R4");
        // direct value: 100 at k=0, QP 0 -> 40
        if (quant(100, 0, 0) != 40) report("R5", "model self", quant(100, 0, 0), 40);
        compared++;

        // R5: sweep every legal QP with varied coefficients
        for (int q = 0; q <= 51; q++)
            for (int k = 0; k < 16; k++)
                step(1, (k * 2311 + q * 977) % 8000 - 4000, q, "R5");

        // R6: signs, zeros and extremes
        for (int k = 0; k < 16; k++) begin
            int vals[8] = '{0, 1, -1, 32767, -32768, -32767, 7, 0};
            step(1, vals[k % 8], k % 2 ? 0 : 40, "R6");
        end

        // R7: out-of-range QP clamps
        for (int q = 52; q < 64; q++)
            for (int k = 0; k < 16; k++)
                step(1, 30000 - k * 3001, q, "R7");

        // R8: QP changes every cycle inside a block
        for (int b = 0; b < 6; b++)
            for (int k = 0; k < 16; k++)
                step(1, 1500 * (k - 7), (b * 9 + k * 5) % 64, "R8");

        // R2 R3: gaps inside blocks
        for (int b = 0; b < 3; b++)
            for (int k = 0; k < 16; k++) begin
                step(1, 999 - k * 111, 12 + b * 10, "R3");
                if (k % 3 == 0) idle(k % 4 + 1, "R2");
            end

        // R9: random coefficients and QP
        for (int i = 0; i < 400; i++)
            step(1, int'($urandom_range(65535)) - 32768, int'($urandom_range(63)), "R9");

        idle(4, "R2");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule